// File: doc/BRIEF.md
# Serial Register Access Master

This block lets on-chip logic read or write one 8-bit register of an external peripheral controller over a four-wire full-duplex serial link. A requester presents a register number (0 to 31), a direction flag and, for writes, a data byte on a valid/ready handshake. The block then drives one framed two-byte exchange and returns the two bytes it collected from the peripheral.

In the first byte the block sends a command that encodes the register number and the direction. Meanwhile the peripheral answers with a status byte, and the block hands that byte back with every transaction. In the second byte the block sends either the write value or a zero filler. For a read, the byte it receives during this second byte is the register contents. The serial clock is derived from the system clock by a fixed even ratio. Chip select stays low for exactly sixteen serial clock pulses, with a guard interval on each side, and it stays high for at least one serial period between frames.

Top module: `spi_regport`

## Requirements
- R1: After reset, and whenever no frame is in progress, `spi_cs_n` is 1, `spi_sclk` is 0 and `spi_mosi` is 0. `req_ready` is 1 after reset.
- R2: The first byte sent is the command byte. It has the register number in bits 7:3, bit 1 set to 1 for a write and 0 for a read, and bits 2 and 0 at 0.
- R3: The second byte sent is `req_wdata` for a write and 0x00 for a read.
- R4: Bits go out most significant first. `spi_mosi` changes only while `spi_sclk` is low. `spi_miso` is sampled during the high phase of `spi_sclk`.
- R5: Each frame holds `spi_cs_n` low across exactly 16 rising edges of `spi_sclk`.
- R6: On the `done` cycle, `rsp_status` equals the byte received while the command byte was sent, first received bit as bit 7.
- R7: On the `done` cycle, `rsp_rdata` equals the byte received during the second byte, first received bit as bit 7.
- R8: Each serial clock period lasts CLK_DIV system cycles (default 4): CLK_DIV/2 high and CLK_DIV/2 low.
- R9: At least CLK_DIV system cycles pass between the fall of `spi_cs_n` and the first rising edge of `spi_sclk`. At least CLK_DIV cycles pass between the last falling edge and the rise of `spi_cs_n`.
- R10: `req_ready` is 0 from the cycle after a request is accepted until `done`. `done` is a one-cycle pulse that coincides with `req_ready` returning to 1.
- R11: Between frames, `spi_cs_n` stays high for at least CLK_DIV system cycles, even when the next request is already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 5 | Register number |
| req_wdata | input | 8 | Data byte for a write |
| done | output | 1 | One-cycle pulse: transaction finished |
| rsp_status | output | 8 | Status byte received during the command byte |
| rsp_rdata | output | 8 | Byte received during the second byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The embedded assertions check some rules on every cycle: the quiet line levels outside a frame, a stable data-out line through each high clock phase, the count of sixteen clock pulses per frame, and the coupling of `done`, `req_ready` and chip select. The bench's scenarios cover everything that needs a model of the peripheral. A behavioural peripheral decodes the command and filler bytes, returns chosen status and register values, and takes writes so that later reads can show them. The same scenarios measure the serial period, the chip-select setup and hold margins, and the gap between back-to-back frames.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_SHIFT,
        SEQ_HOLD,
        SEQ_GAP
    } seq_state_e;

    // Command byte: register number high, direction flag in bit 1.
    function automatic logic [7:0] build_cmd(input logic [4:0] regnum, input logic wr);
        return {regnum, 1'b0, wr, 1'b0};
    endfunction

endpackage

// File: rtl/spi_regport_tick.sv
module spi_regport_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    generate
        if (HALF == 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run)
                    cnt_d = '0;
                else if (cnt_q == CNT_W'(HALF - 1))
                    cnt_d = '0;
                else
                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = run && (cnt_q == CNT_W'(HALF - 1));
        end
    endgenerate

endmodule

// File: rtl/spi_regport_shift.sv
module spi_regport_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_cmd,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_first,
    output logic [DATA_W-1:0] rx_second
);
    localparam int FRAME_W = 2 * DATA_W;

    typedef struct packed {
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
    } shift_regs_t;

    shift_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.tx = {load_cmd, load_data};
        end else if (sample) begin
            r_d.rx = {r_q.rx[FRAME_W-2:0], miso};
            r_d.tx = {r_q.tx[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mosi      = r_q.tx[FRAME_W-1];
    assign rx_first  = r_q.rx[FRAME_W-1:DATA_W];
    assign rx_second = r_q.rx[DATA_W-1:0];

    // The transmit word is fully shifted out by the end of a frame.
    AST_TX_EMPTY_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (r_q.tx == '0)) else $error("AST_TX_EMPTY_AT_LOAD"); // R1

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
    import spi_regport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic tick,
    output logic ready,
    output logic load,
    output logic run,
    output logic sample,
    output logic cs_n,
    output logic sclk,
    output logic done
);
    localparam int LAST_PH = 4 * DATA_W - 1;
    localparam int PH_W    = $clog2(4 * DATA_W);

    typedef struct packed {
        seq_state_e      state;
        logic [PH_W-1:0] ph;
        logic            cs_n;
        logic            sclk;
        logic            done;
    } ctrl_regs_t;

    ctrl_regs_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        sample   = 1'b0;
        case (c_q.state)
            SEQ_IDLE: begin
                if (req_valid) begin
                    c_d.state = SEQ_SETUP;
                    c_d.ph    = '0;
                    c_d.cs_n  = 1'b0;
                end
            end
            SEQ_SETUP: begin
                if (tick) begin
                    if (c_q.ph == PH_W'(1)) begin
                        c_d.state = SEQ_SHIFT;
                        c_d.ph    = '0;
                    end else begin
                        c_d.ph = c_q.ph + 1'b1;
                    end
                end
            end
            SEQ_SHIFT: begin
                if (tick) begin
                    if (!c_q.ph[0]) begin
                        c_d.sclk = 1'b1;
                        c_d.ph   = c_q.ph + 1'b1;
                    end else begin
                        c_d.sclk = 1'b0;
                        sample   = 1'b1;
                        if (c_q.ph == PH_W'(LAST_PH)) begin
                            c_d.state = SEQ_HOLD;
                            c_d.ph    = '0;
                        end else begin
                            c_d.ph = c_q.ph + 1'b1;
                        end
                    end
                end
            end
            SEQ_HOLD: begin
                if (tick) begin
                    if (c_q.ph == PH_W'(1)) begin
                        c_d.state = SEQ_GAP;
                        c_d.ph    = '0;
                        c_d.cs_n  = 1'b1;
                    end else begin
                        c_d.ph = c_q.ph + 1'b1;
                    end
                end
            end
            SEQ_GAP: begin
                if (tick) begin
                    if (c_q.ph == PH_W'(1)) begin
                        c_d.state = SEQ_IDLE;
                        c_d.ph    = '0;
                        c_d.done  = 1'b1;
                    end else begin
                        c_d.ph = c_q.ph + 1'b1;
                    end
                end
            end
            default: begin
                c_d = '{state: SEQ_IDLE, ph: '0, cs_n: 1'b1, sclk: 1'b0, done: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: SEQ_IDLE, ph: '0, cs_n: 1'b1, sclk: 1'b0, done: 1'b0};
        else        c_q <= c_d;
    end

    assign ready = (c_q.state == SEQ_IDLE);
    assign load  = ready && req_valid;
    assign run   = !ready;
    assign cs_n  = c_q.cs_n;
    assign sclk  = c_q.sclk;
    assign done  = c_q.done;

    AST_NO_EDGE_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.cs_n) |-> !c_q.sclk) else $error("AST_NO_EDGE_AT_SELECT"); // R9
    AST_DESELECT_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.cs_n) |-> !c_q.sclk && !$past(c_q.sclk)) else $error("AST_DESELECT_CLOCK_LOW"); // R9

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_write,
    input  logic [4:0] req_reg,
    input  logic [7:0] req_wdata,
    output logic       done,
    output logic [7:0] rsp_status,
    output logic [7:0] rsp_rdata,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int DATA_W = 8;
    localparam int HALF   = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam int EDGES  = 2 * DATA_W;

    logic tick, load, run, sample;

    spi_regport_tick #(.HALF(HALF)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    spi_regport_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .tick     (tick),
        .ready    (req_ready),
        .load     (load),
        .run      (run),
        .sample   (sample),
        .cs_n     (spi_cs_n),
        .sclk     (spi_sclk),
        .done     (done)
    );

    spi_regport_shift #(.DATA_W(DATA_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_cmd (build_cmd(req_reg, req_write)),
        .load_data(req_write ? req_wdata : 8'h00),
        .sample   (sample),
        .miso     (spi_miso),
        .mosi     (spi_mosi),
        .rx_first (rsp_status),
        .rx_second(rsp_rdata)
    );

    // Pulse counter used only by the frame-length assertion.
    logic [5:0] edge_cnt_q;
    logic       sclk_prev_q, cs_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q  <= '0;
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b1;
        end else begin
            sclk_prev_q <= spi_sclk;
            cs_prev_q   <= spi_cs_n;
            if (!spi_cs_n && spi_sclk && !sclk_prev_q)
                edge_cnt_q <= edge_cnt_q + 1'b1;
            else if (spi_cs_n && cs_prev_q)
                edge_cnt_q <= '0;
        end
    end

    AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_sclk && !spi_mosi)) else $error("AST_QUIET_LINES"); // R1
    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)) else $error("AST_MOSI_STEADY_HIGH"); // R4
    AST_SIXTEEN_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (edge_cnt_q == 6'(EDGES))) else $error("AST_SIXTEEN_PULSES"); // R5
    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && spi_cs_n)) else $error("AST_DONE_WITH_READY"); // R10
    AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !req_ready) else $error("AST_BUSY_WHILE_SELECTED"); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("AST_DONE_SINGLE"); // R10

endmodule

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [4:0] req_reg = '0;
    logic [7:0] req_wdata = '0;
    logic       done;
    logic [7:0] rsp_status, rsp_rdata;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regport #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
        .done(done), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // ---------------- behavioural peripheral ----------------
    int         cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    logic [7:0] pr_regs [32];
    logic [7:0] pr_status = 8'h00;
    logic [7:0] pr_out = 8'h00;
    logic [15:0] pr_in = '0;
    int  pr_rises = 0;
    int  t_sel, t_first_rise, t_last_rise, t_last_fall, t_desel, t_prev_desel;
    bit  period_bad, mosi_moved_high;
    logic [15:0] frame_in;
    int  frame_rises, frame_setup, frame_hold, frame_gap;
    bit  frame_period_bad, frame_mosi_bad;

    assign spi_miso = pr_out[7];

    initial begin
        for (int i = 0; i < 32; i++) pr_regs[i] = 8'(i * 7 + 3);
        t_prev_desel = -1000;
    end

    always @(negedge spi_cs_n) begin
        pr_out = pr_status;
        pr_rises = 0;
        period_bad = 0;
        mosi_moved_high = 0;
        t_sel = cyc;
        frame_gap = cyc - t_prev_desel;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            pr_in = {pr_in[14:0], spi_mosi};
            if (pr_rises == 0) t_first_rise = cyc;
            else if (cyc - t_last_rise != DIV) period_bad = 1;
            t_last_rise = cyc;
            pr_rises++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (cyc - t_last_rise != DIV/2) period_bad = 1;
            t_last_fall = cyc;
            if (pr_rises == 8) pr_out = pr_regs[pr_in[7:3]];
            else pr_out = {pr_out[6:0], 1'b0};
        end
    end

    always @(spi_mosi) if (spi_sclk && !spi_cs_n) mosi_moved_high = 1;

    always @(posedge spi_cs_n) begin
        t_desel = cyc;
        t_prev_desel = cyc;
        frame_in = pr_in;
        frame_rises = pr_rises;
        frame_setup = t_first_rise - t_sel;
        frame_hold = t_desel - t_last_fall;
        frame_period_bad = period_bad;
        frame_mosi_bad = mosi_moved_high;
        if (pr_in[9]) pr_regs[pr_in[15:11]] = pr_in[7:0];
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [4:0] rg, input logic [7:0] wd,
                        input logic [7:0] st, output logic [7:0] got_st, output logic [7:0] got_rd);
        pr_status = st;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_reg = rg; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
        while (!done) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready with done", req_ready, 1);
        got_st = rsp_status;
        got_rd = rsp_rdata;
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        // frame properties seen by the peripheral
        chk(frame_in[15:8] == {rg, 1'b0, wr, 1'b0}, "R2 command byte", frame_in[15:8], {rg, 1'b0, wr, 1'b0});
        chk(frame_in[7:0] == (wr ? wd : 8'h00), "R3 second byte", frame_in[7:0], wr ? wd : 8'h00);
        chk(frame_rises == 16, "R5 pulses per frame", frame_rises, 16);
        chk(!frame_period_bad, "R8 serial period", frame_period_bad, 0);
        chk(!frame_mosi_bad, "R4 mosi steady while high", frame_mosi_bad, 0);
        chk(frame_setup >= DIV, "R9 select setup", frame_setup, DIV);
        chk(frame_hold >= DIV, "R9 select hold", frame_hold, DIV);
        chk(got_st == st, "R6 status byte", got_st, st);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 cs idle", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1 sclk idle", spi_sclk, 0);
        chk(spi_mosi == 1'b0, "R1 mosi idle", spi_mosi, 0);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_reads();
        logic [7:0] s, d;
        xfer(1'b0, 5'd0, 8'hEE, 8'h5A, s, d);
        chk(d == 8'h03, "R7 read reg 0", d, 8'h03);
        xfer(1'b0, 5'd31, 8'h00, 8'h81, s, d);
        chk(d == 8'(31*7+3), "R7 read reg 31", d, 8'(31*7+3));
        xfer(1'b0, 5'd19, 8'h00, 8'hFF, s, d);
        chk(d == 8'(19*7+3), "R7 read reg 19", d, 8'(19*7+3));
        chk(spi_cs_n && !spi_sclk && !spi_mosi, "R1 lines quiet after frame",
            {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
    endtask

    task automatic t_writes();
        logic [7:0] s, d;
        xfer(1'b1, 5'd7, 8'h3C, 8'h00, s, d);
        xfer(1'b0, 5'd7, 8'h00, 8'h12, s, d);
        chk(d == 8'h3C, "R7 readback after write", d, 8'h3C);
        xfer(1'b1, 5'd21, 8'hA5, 8'h80, s, d);
        xfer(1'b0, 5'd21, 8'h00, 8'h01, s, d);
        chk(d == 8'hA5, "R7 readback pattern A5", d, 8'hA5);
    endtask

    task automatic t_back_to_back();
        // Request asserted again at once after done: gap must still hold.
        logic [7:0] s, d;
        pr_status = 8'h66;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_reg = 5'd2; req_wdata = 8'h00;
        for (int k = 0; k < 2; k++) begin
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            while (!done) @(negedge clk);
        end
        req_valid = 1'b0;
        s = rsp_status; d = rsp_rdata;
        chk(frame_gap >= DIV, "R11 deselect gap", frame_gap, DIV);
        chk(d == 8'(2*7+3), "R7 back-to-back read", d, 8'(2*7+3));
        chk(s == 8'h66, "R6 back-to-back status", s, 8'h66);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reads();
        t_writes();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule